// File: doc/BRIEF.md
# Address Space Select and Prefix Mapper

This block wraps a page-table walker on both sides. On the way in, it looks at an access request and decides what to do with it. The request carries an access kind (read, write or instruction fetch), a translation-enable bit, an address-space mode and three address-space descriptors (primary, secondary and home). The block then does one of three things:

- it bypasses translation altogether;
- it rejects the request because its mode is unsupported;
- it sends a walk request to the walker, carrying the page-aligned virtual address and the chosen descriptor.

On the way out, it takes the walker's real address and permission flags and trims the permissions according to the mode. It then converts the real address to an absolute address through a programmable prefix, which swaps the lowest 8 KB with the 8 KB window at the prefix.

The final result appears one cycle after the walker reports completion. For bypassed or rejected requests, it appears one cycle after the request. Only one walk is in flight at a time. A walker completion in the same cycle as a new bypass or rejected request takes priority over that request.

Top module: `addr_space_mapper`

## Requirements
- R1: With `dat_en_i` low, a request raises no walk request. The next cycle carries a result whose address is the page-aligned virtual address after prefix mapping and whose permissions are `3'b111`. Permission bit 2 is read, bit 1 is write and bit 0 is execute.
- R2: With translation on, mode 0 (primary) walks with `cr_pri_i` and mode 3 (home) walks with `cr_home_i`. In both modes the walker's permissions are returned unchanged.
- R3: In mode 2 (secondary), an instruction fetch (access code 2) walks with `cr_pri_i`, and only the execute bit survives in the result.
- R4: In mode 2, a data access (codes 0, 1 and 3) walks with `cr_sec_i`, and the execute bit is cleared in the result.
- R5: `walk_vaddr_o` is the request address with its low `PAGE_BITS` (12) bits forced to zero.
- R6: A real address below 0x2000 maps to that address plus `prefix_i`.
- R7: A real address at or above `prefix_i` and below `prefix_i`+0x2000 maps to that address minus `prefix_i`. Any other address is unchanged.
- R8: With translation on, mode 1 raises no walk request. The next cycle carries a result with `res_err_o` high, address 0 and permissions 0.
- R9: `res_valid_o` is low after reset. It is high exactly one cycle after a walker completion or after a bypassed or rejected request, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request strobe |
| req_vaddr_i | input | ADDR_W | Virtual address of the request |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 treated as data |
| dat_en_i | input | 1 | Translation enable |
| asc_mode_i | input | 2 | Address-space mode: 0 primary, 1 unsupported, 2 secondary, 3 home |
| cr_pri_i | input | ADDR_W | Primary space descriptor |
| cr_sec_i | input | ADDR_W | Secondary space descriptor |
| cr_home_i | input | ADDR_W | Home space descriptor |
| prefix_i | input | ADDR_W | Prefix value for real-to-absolute mapping |
| walk_req_o | output | 1 | Start a walk |
| walk_vaddr_o | output | ADDR_W | Page-aligned address for the walker |
| walk_asce_o | output | ADDR_W | Descriptor chosen for the walk |
| walk_done_i | input | 1 | Walker completion strobe |
| walk_raddr_i | input | ADDR_W | Real address from the walker |
| walk_perm_i | input | 3 | Walker permissions {read, write, execute} |
| res_valid_o | output | 1 | Result strobe |
| res_addr_o | output | ADDR_W | Absolute address |
| res_perm_o | output | 3 | Final permissions {read, write, execute} |
| res_err_o | output | 1 | Unsupported mode reported |

## Verification
The hardest situation to reach is the secondary-mode permission trimming. It depends on context captured at request time and applied only when the walker answers several cycles later. The bench therefore issues a secondary fetch and a secondary data access back to back. It supplies full permissions from its emulated walker with a gap between request and completion, so that a mask taken from live inputs rather than from the captured context would show up. The prefix swap boundaries (exactly 0x2000 above the prefix, and an address inside the prefix window) are reached through the bypass path, so the addresses can be chosen freely.

// File: rtl/asm_pkg.sv
package asm_pkg;
  typedef enum logic [1:0] {
    ASC_PRI    = 2'd0,
    ASC_UNSUPP = 2'd1,
    ASC_SEC    = 2'd2,
    ASC_HOME   = 2'd3
  } asc_mode_e;

  typedef enum logic [1:0] {
    ACC_RD    = 2'd0,
    ACC_WR    = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSV   = 2'd3
  } acc_kind_e;

  localparam int PERM_W = 3;
  localparam logic [PERM_W-1:0] PERM_ALL  = 3'b111;
  localparam logic [PERM_W-1:0] PERM_X    = 3'b001;
  localparam logic [PERM_W-1:0] PERM_NOTX = 3'b110;
endpackage

// File: rtl/asm_req_sel.sv
module asm_req_sel
  import asm_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12
) (
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [1:0]        acc_i,
  input  logic              dat_en_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] cr_pri_i,
  input  logic [ADDR_W-1:0] cr_sec_i,
  input  logic [ADDR_W-1:0] cr_home_i,
  output logic              walk_req_o,
  output logic              bypass_o,
  output logic              bad_mode_o,
  output logic [ADDR_W-1:0] vaddr_al_o,
  output logic [ADDR_W-1:0] asce_o
);
  asc_mode_e mode;
  logic      fetch;

  assign mode  = asc_mode_e'(mode_i);
  assign fetch = (acc_kind_e'(acc_i) == ACC_FETCH);

  assign vaddr_al_o = {vaddr_i[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};

  assign bypass_o   = req_valid_i && !dat_en_i;
  assign bad_mode_o = req_valid_i && dat_en_i && (mode == ASC_UNSUPP);
  assign walk_req_o = req_valid_i && dat_en_i && (mode != ASC_UNSUPP);

  always_comb begin
    unique case (mode)
      ASC_PRI:  asce_o = cr_pri_i;
      ASC_HOME: asce_o = cr_home_i;
      ASC_SEC:  asce_o = fetch ? cr_pri_i : cr_sec_i;
      default:  asce_o = '0;
    endcase
  end
endmodule

// File: rtl/asm_perm_mask.sv
module asm_perm_mask
  import asm_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic              fetch_i,
  input  logic [PERM_W-1:0] perm_i,
  output logic [PERM_W-1:0] perm_o
);
  logic [PERM_W-1:0] keep;

  always_comb begin
    keep = PERM_ALL;
    if (asc_mode_e'(mode_i) == ASC_SEC) keep = fetch_i ? PERM_X : PERM_NOTX;
  end

  assign perm_o = perm_i & keep;
endmodule

// File: rtl/asm_prefix_map.sv
module asm_prefix_map #(
  parameter int ADDR_W   = 64,
  parameter int LOW_SPAN = 8192
) (
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic [ADDR_W-1:0] prefix_i,
  output logic [ADDR_W-1:0] aaddr_o
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(LOW_SPAN);

  logic [ADDR_W:0] r_ext, p_ext, p_end;
  logic            in_low, in_pre;

  assign r_ext  = {1'b0, raddr_i};
  assign p_ext  = {1'b0, prefix_i};
  assign p_end  = p_ext + SPAN;
  assign in_low = r_ext < SPAN;
  assign in_pre = (r_ext >= p_ext) && (r_ext < p_end);

  always_comb begin
    if (in_low)      aaddr_o = raddr_i + prefix_i;
    else if (in_pre) aaddr_o = raddr_i - prefix_i;
    else             aaddr_o = raddr_i;
  end
endmodule

// File: rtl/addr_space_mapper.sv
module addr_space_mapper
  import asm_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int LOW_SPAN  = 8192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic [1:0]        req_acc_i,
  input  logic              dat_en_i,
  input  logic [1:0]        asc_mode_i,
  input  logic [ADDR_W-1:0] cr_pri_i,
  input  logic [ADDR_W-1:0] cr_sec_i,
  input  logic [ADDR_W-1:0] cr_home_i,
  input  logic [ADDR_W-1:0] prefix_i,
  output logic              walk_req_o,
  output logic [ADDR_W-1:0] walk_vaddr_o,
  output logic [ADDR_W-1:0] walk_asce_o,
  input  logic              walk_done_i,
  input  logic [ADDR_W-1:0] walk_raddr_i,
  input  logic [2:0]        walk_perm_i,
  output logic              res_valid_o,
  output logic [ADDR_W-1:0] res_addr_o,
  output logic [2:0]        res_perm_o,
  output logic              res_err_o
);
  logic              bypass, bad_mode;
  logic [1:0]        ctx_mode_q;
  logic              ctx_fetch_q;
  logic [PERM_W-1:0] perm_masked;
  logic [ADDR_W-1:0] pre_addr, abs_addr;
  logic              nxt_valid, nxt_err;
  logic [PERM_W-1:0] nxt_perm;

  asm_req_sel #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_sel (
    .req_valid_i (req_valid_i),
    .vaddr_i     (req_vaddr_i),
    .acc_i       (req_acc_i),
    .dat_en_i    (dat_en_i),
    .mode_i      (asc_mode_i),
    .cr_pri_i    (cr_pri_i),
    .cr_sec_i    (cr_sec_i),
    .cr_home_i   (cr_home_i),
    .walk_req_o  (walk_req_o),
    .bypass_o    (bypass),
    .bad_mode_o  (bad_mode),
    .vaddr_al_o  (walk_vaddr_o),
    .asce_o      (walk_asce_o)
  );

  // context of the walk in flight, used when the walker answers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_mode_q  <= '0;
      ctx_fetch_q <= 1'b0;
    end else if (walk_req_o) begin
      ctx_mode_q  <= asc_mode_i;
      ctx_fetch_q <= (acc_kind_e'(req_acc_i) == ACC_FETCH);
    end
  end

  asm_perm_mask u_mask (
    .mode_i  (ctx_mode_q),
    .fetch_i (ctx_fetch_q),
    .perm_i  (walk_perm_i),
    .perm_o  (perm_masked)
  );

  always_comb begin
    nxt_valid = 1'b0;
    nxt_err   = 1'b0;
    nxt_perm  = '0;
    pre_addr  = walk_vaddr_o;
    if (walk_done_i) begin
      nxt_valid = 1'b1;
      nxt_perm  = perm_masked;
      pre_addr  = walk_raddr_i;
    end else if (bypass) begin
      nxt_valid = 1'b1;
      nxt_perm  = PERM_ALL;
    end else if (bad_mode) begin
      nxt_valid = 1'b1;
      nxt_err   = 1'b1;
    end
  end

  asm_prefix_map #(.ADDR_W(ADDR_W), .LOW_SPAN(LOW_SPAN)) u_pfx (
    .raddr_i  (pre_addr),
    .prefix_i (prefix_i),
    .aaddr_o  (abs_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_addr_o  <= '0;
      res_perm_o  <= '0;
      res_err_o   <= 1'b0;
    end else begin
      res_valid_o <= nxt_valid;
      res_err_o   <= nxt_err;
      res_perm_o  <= nxt_perm;
      res_addr_o  <= nxt_err ? '0 : abs_addr;
    end
  end
endmodule

// File: rtl/asm_chk.sv
module asm_chk #(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_acc_i,
  input logic              dat_en_i,
  input logic [1:0]        asc_mode_i,
  input logic [ADDR_W-1:0] cr_pri_i,
  input logic [ADDR_W-1:0] cr_sec_i,
  input logic              walk_req_o,
  input logic [ADDR_W-1:0] walk_vaddr_o,
  input logic [ADDR_W-1:0] walk_asce_o,
  input logic              walk_done_i,
  input logic              res_valid_o,
  input logic [2:0]        res_perm_o,
  input logic              res_err_o
);
  // R1
  no_walk_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !dat_en_i) |-> !walk_req_o);
  // R5
  page_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o |-> (walk_vaddr_o[PAGE_BITS-1:0] == '0));
  // R3
  sec_fetch_asce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && asc_mode_i == 2'd2 && req_acc_i == 2'd2) |-> (walk_asce_o == cr_pri_i));
  // R4
  sec_data_asce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && asc_mode_i == 2'd2 && req_acc_i != 2'd2) |-> (walk_asce_o == cr_sec_i));
  // R8
  bad_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dat_en_i && asc_mode_i == 2'd1 && !walk_done_i) |=> (res_valid_o && res_err_o));
  // R8
  err_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_err_o |-> (res_perm_o == 3'b000));
  // R9
  res_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_done_i || (req_valid_i && !walk_req_o)) |=> res_valid_o);
endmodule

bind addr_space_mapper asm_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_acc_i    (req_acc_i),
  .dat_en_i     (dat_en_i),
  .asc_mode_i   (asc_mode_i),
  .cr_pri_i     (cr_pri_i),
  .cr_sec_i     (cr_sec_i),
  .walk_req_o   (walk_req_o),
  .walk_vaddr_o (walk_vaddr_o),
  .walk_asce_o  (walk_asce_o),
  .walk_done_i  (walk_done_i),
  .res_valid_o  (res_valid_o),
  .res_perm_o   (res_perm_o),
  .res_err_o    (res_err_o)
);

// File: tb/addr_space_mapper_tb.sv
module addr_space_mapper_tb;
  localparam int AW = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_vaddr_i = '0;
  logic [1:0]    req_acc_i = '0;
  logic          dat_en_i = 1'b0;
  logic [1:0]    asc_mode_i = '0;
  logic [AW-1:0] cr_pri_i = 64'h0000_0000_0A00_0000;
  logic [AW-1:0] cr_sec_i = 64'h0000_0000_0B00_0000;
  logic [AW-1:0] cr_home_i = 64'h0000_0000_0C00_0000;
  logic [AW-1:0] prefix_i = '0;
  logic          walk_req_o;
  logic [AW-1:0] walk_vaddr_o, walk_asce_o;
  logic          walk_done_i = 1'b0;
  logic [AW-1:0] walk_raddr_i = '0;
  logic [2:0]    walk_perm_i = '0;
  logic          res_valid_o;
  logic [AW-1:0] res_addr_o;
  logic [2:0]    res_perm_o;
  logic          res_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  addr_space_mapper u_dut (.*);

  function automatic void check(string tag, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  function automatic longint unsigned pfx_model(longint unsigned a, longint unsigned p);
    if (a < 64'h2000) return a + p;
    if (a >= p && (a - p) < 64'h2000) return a - p;
    return a;
  endfunction

  function automatic logic [2:0] perm_model(int mode, int acc, logic [2:0] p);
    if (mode == 2) return (acc == 2) ? {2'b00, p[0]} : {p[2:1], 1'b0};
    return p;
  endfunction

  // cycle model, compared after every rising edge
  bit          e_v, e_err;
  longint unsigned e_addr;
  logic [2:0]  e_perm;
  string       e_tag = "R9";
  int          m_mode, m_acc;

  always @(posedge clk_i) begin
    bit walk;
    if (!rst_ni) begin
      e_v = 0;
    end else begin
      walk = req_valid_i && dat_en_i && asc_mode_i != 2'd1;
      e_v = 0; e_err = 0; e_perm = 0; e_addr = 0;
      if (walk_done_i) begin
        e_v = 1;
        e_perm = perm_model(m_mode, m_acc, walk_perm_i);
        e_addr = pfx_model(walk_raddr_i, prefix_i);
        e_tag = (m_mode == 2) ? ((m_acc == 2) ? "R3" : "R4") : "R2";
      end else if (req_valid_i && !dat_en_i) begin
        e_v = 1;
        e_perm = 3'b111;
        e_addr = pfx_model(req_vaddr_i & ~64'hFFF, prefix_i);
        e_tag = "R1/R6/R7";
      end else if (req_valid_i && !walk) begin
        e_v = 1; e_err = 1;
        e_tag = "R8";
      end else e_tag = "R9";
      if (walk) begin
        m_mode = asc_mode_i;
        m_acc = req_acc_i;
      end
    end
    #2;
    check({e_tag, " valid"}, res_valid_o, e_v);
    if (e_v) begin
      check({e_tag, " addr"}, res_addr_o, e_addr);
      check({e_tag, " perm"}, res_perm_o, e_perm);
      check({e_tag, " err"}, res_err_o, e_err);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bypass_req(longint unsigned va);
    @(negedge clk_i);
    dat_en_i = 0; req_valid_i = 1; req_vaddr_i = va;
    #1 check("R1 no walk", walk_req_o, 0);
    @(negedge clk_i);
    req_valid_i = 0;
    idle(1);
  endtask

  task automatic walk_req(int mode, int acc, longint unsigned va, longint unsigned exp_asce,
                          string tag, longint unsigned ra, logic [2:0] wp);
    @(negedge clk_i);
    dat_en_i = 1; req_valid_i = 1; req_vaddr_i = va;
    asc_mode_i = 2'(mode); req_acc_i = 2'(acc);
    #1;
    check({tag, " walk_req"}, walk_req_o, 1);
    check({tag, " asce"}, walk_asce_o, exp_asce);
    check("R5 vaddr align", walk_vaddr_o, va & ~64'hFFF);
    @(negedge clk_i);
    req_valid_i = 0;
    // live inputs change to expose a mask taken from them instead of the context
    asc_mode_i = 2'd0; req_acc_i = 2'd0;
    idle(1);
    walk_done_i = 1; walk_raddr_i = ra; walk_perm_i = wp;
    @(negedge clk_i);
    walk_done_i = 0;
    idle(1);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    if (!finished) begin
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    check("R9 reset valid", res_valid_o, 0);
    check("R9 reset walk_req", walk_req_o, 0);
    rst_ni = 1;
    idle(2);

    // R1 bypass, alignment, no prefix
    prefix_i = 64'h0;
    bypass_req(64'h1234_5678);
    // R6 low region plus prefix
    prefix_i = 64'h4_0000;
    bypass_req(64'h1ABC);
    // R7 inside prefix window and just above it
    bypass_req(64'h4_1234);
    bypass_req(64'h4_2000);
    bypass_req(64'h2000);

    // R2 primary and home
    walk_req(0, 0, 64'h7777_7FFF, cr_pri_i, "R2", 64'h0030_0000, 3'b110);
    walk_req(3, 1, 64'h9000_1001, cr_home_i, "R2", 64'h1000, 3'b111);
    // R3 secondary fetch, R4 secondary data
    walk_req(2, 2, 64'h5555_5555, cr_pri_i, "R3", 64'h4_1000, 3'b111);
    walk_req(2, 0, 64'h6666_6666, cr_sec_i, "R4", 64'h8_8000, 3'b111);
    walk_req(2, 3, 64'h6666_7000, cr_sec_i, "R4", 64'h8_9000, 3'b101);

    // R8 unsupported mode
    @(negedge clk_i);
    dat_en_i = 1; req_valid_i = 1; asc_mode_i = 2'd1; req_vaddr_i = 64'hABC000;
    #1 check("R8 no walk", walk_req_o, 0);
    @(negedge clk_i);
    req_valid_i = 0;
    idle(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule